// File: doc/BRIEF.md
# Keyed Peripheral Reset Pulser

This block lets software reset individual peripherals through a small register window, while keeping those resets behind a key-protected guard. Five 32-bit reset-request words together address 160 peripherals. A separate guard register accepts two 32-bit key values. One key opens the guard and the other closes it. Any other value written there is ignored.

While the guard is open, every 1 written into a reset-request word starts a fixed-length reset pulse on the matching output bit. The written bit clears itself when its pulse ends. While the guard is closed, writes to the request words are dropped. The block comes out of reset with the guard closed.

Software normally opens the guard, writes one or more request words, and then closes the guard again. The written request bits can be read back while their pulses are running.

Top module: `prst_guard`

## Requirements
- R1: After reset the guard is closed: `rst_pulse` is all zero and a read of the guard register (address 0x84) returns 0.
- R2: Writing 0xA6382D4C to address 0x84 opens the guard. From the next cycle on, a read of 0x84 returns 1 (bit 0 set, all other bits 0).
- R3: Writing 0xA6382D4D to address 0x84 closes the guard. From the next cycle on, a read of 0x84 returns 0 and request writes are dropped.
- R4: Writing any other value to address 0x84 leaves the guard state unchanged, whether it is open or closed.
- R5: While the guard is closed, a write to a request word is discarded and starts no pulse.
- R6: While the guard is open, writing 1 to bit b of the request word at address 0x70+4*k drives `rst_pulse[32*k+b]` high for exactly PULSE_LEN (default 4) cycles, starting in the cycle after the write edge. Bits written as 0 leave their outputs unchanged.
- R7: A read of request word k returns the bits of that word whose pulse is still running. Each bit reads 0 once its pulse has ended.
- R8: While the guard stays open, successive writes to different request words each start their own pulses.
- R9: Writing 1 again to a bit whose pulse is still running restarts that pulse at its full length.
- R10: A write to an address that is neither 0x84 nor a request word changes nothing. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_pulse | output | 160 | Per-peripheral reset pulses, active high |

## Verification
The bench sends guard writes that mix the two keys with random values. This separates key matching from a plain "any write to 0x84" decode, and it tests that each key works from either guard state. Request writes are made both with the guard open and with it closed. They use sparse random bit patterns across all five words plus a few stray addresses, so that a missing guard check, a wrong word offset or a wrong bit lane each shows up at a specific output bit. Directed cases count how many cycles a pulse stays high, re-arm a bit while its pulse is running, and read request words during and after a pulse. Together these pin down the pulse length, the restart behaviour and the self-clearing read-back.

// File: rtl/prst_pkg.sv
package prst_pkg;
  typedef enum logic [1:0] {
    GUARD_KEEP  = 2'd0,
    GUARD_OPEN  = 2'd1,
    GUARD_CLOSE = 2'd2
  } guard_cmd_e;
endpackage

// File: rtl/prst_key_lock.sv
module prst_key_lock #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  GUARD_ADDR = 8'h84,
  parameter logic [31:0] OPEN_KEY   = 32'hA6382D4C,
  parameter logic [31:0] CLOSE_KEY  = 32'hA6382D4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_o
);
  import prst_pkg::*;

  guard_cmd_e cmd;
  logic       open_q, open_d;

  // key decode
  always_comb begin
    cmd = GUARD_KEEP;
    if (wr_en && (wr_addr == ADDR_W'(GUARD_ADDR))) begin
      if (wr_data == DATA_W'(OPEN_KEY))       cmd = GUARD_OPEN;
      else if (wr_data == DATA_W'(CLOSE_KEY)) cmd = GUARD_CLOSE;
    end
  end

  // next state
  always_comb begin
    open_d = open_q;
    case (cmd)
      GUARD_OPEN:  open_d = 1'b1;
      GUARD_CLOSE: open_d = 1'b0;
      default:     open_d = open_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign open_o = open_q;
endmodule

// File: rtl/prst_pulse_word.sv
module prst_pulse_word #(
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] arm_i,
  output logic [DATA_W-1:0] pulse_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    assign cnt_en = arm_i[b] || (cnt_q != '0);

    always_comb begin
      if (arm_i[b]) cnt_d = CNT_W'(PULSE_LEN);
      else          cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign pulse_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/prst_guard.sv
module prst_guard #(
  parameter int          NUM_WORDS  = 5,
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter int          PULSE_LEN  = 4,
  parameter logic [7:0]  REQ_BASE   = 8'h70,
  parameter logic [7:0]  GUARD_ADDR = 8'h84,
  parameter logic [31:0] OPEN_KEY   = 32'hA6382D4C,
  parameter logic [31:0] CLOSE_KEY  = 32'hA6382D4D
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_WORDS*DATA_W-1:0] rst_pulse
);
  localparam int STRIDE = DATA_W / 8;

  logic                 unlocked;
  logic [NUM_WORDS-1:0] word_sel;
  logic                 wr_accept;

  prst_key_lock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_ADDR(GUARD_ADDR),
    .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)
  ) lock_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .open_o(unlocked)
  );

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(int'(REQ_BASE) + STRIDE * k);
    logic [DATA_W-1:0] arm;

    assign word_sel[k] = (bus_addr == WADDR);
    assign arm = (bus_wr && unlocked && word_sel[k]) ? bus_wdata : '0;

    prst_pulse_word #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) pw_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm),
      .pulse_o(rst_pulse[k*DATA_W +: DATA_W])
    );
  end

  assign wr_accept = bus_wr && unlocked && (|word_sel);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(GUARD_ADDR)) bus_rdata = DATA_W'(unlocked);
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (word_sel[k]) bus_rdata = rst_pulse[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/prst_guard_chk.sv
module prst_guard_chk #(
  parameter int          NW         = 160,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  GUARD_ADDR = 8'h84,
  parameter logic [31:0] OPEN_KEY   = 32'hA6382D4C,
  parameter logic [31:0] CLOSE_KEY  = 32'hA6382D4D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              unlocked,
  input logic              wr_accept,
  input logic [NW-1:0]     rst_pulse
);
  logic guard_wr;
  assign guard_wr = bus_wr && (bus_addr == ADDR_W'(GUARD_ADDR));

  p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && bus_wdata == DATA_W'(OPEN_KEY) |=> unlocked);

  p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && bus_wdata == DATA_W'(CLOSE_KEY) |=> !unlocked);

  p_other_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && bus_wdata != DATA_W'(OPEN_KEY) && bus_wdata != DATA_W'(CLOSE_KEY)
    |=> $stable(unlocked));

  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && rst_pulse == '0 |=> rst_pulse == '0);

  p_arm_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && bus_wdata != '0 |=> rst_pulse != '0);

  p_rise_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse & ~$past(rst_pulse)) != '0 |-> $past(wr_accept));
endmodule

bind prst_guard prst_guard_chk #(
  .NW(NUM_WORDS*DATA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .GUARD_ADDR(GUARD_ADDR), .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .wr_accept(wr_accept),
  .rst_pulse(rst_pulse)
);

// File: tb/prst_guard_tb_top.sv
module prst_guard_tb_top;
  localparam int NB = 160;
  localparam int PLEN = 4;
  localparam logic [31:0] KOPEN = 32'hA6382D4C;
  localparam logic [31:0] KCLOSE = 32'hA6382D4D;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NB-1:0] rst_pulse;

  always #2 clk = ~clk;

  prst_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_pulse(rst_pulse)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_cnt [NB];
  bit m_open;
  int watch_idx = -1;
  int watch_hits = 0;

  function automatic logic [NB-1:0] exp_vec();
    logic [NB-1:0] v = '0;
    for (int i = 0; i < NB; i++) v[i] = (m_cnt[i] != 0);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [NB-1:0] v = exp_vec();
    if (a == 8'h84) return {31'b0, m_open};
    for (int k = 0; k < 5; k++)
      if (a == 8'(8'h70 + 4*k)) return v[k*32 +: 32];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit wr, input logic [7:0] a, input logic [31:0] d);
    bit was_open = m_open;
    for (int i = 0; i < NB; i++) if (m_cnt[i] > 0) m_cnt[i]--;
    if (wr && was_open)
      for (int k = 0; k < 5; k++)
        if (a == 8'(8'h70 + 4*k))
          for (int b = 0; b < 32; b++) if (d[b]) m_cnt[k*32+b] = PLEN;
    if (wr && a == 8'h84) begin
      if (d == KOPEN) m_open = 1'b1;
      else if (d == KCLOSE) m_open = 1'b0;
    end
  endtask

  task automatic cycle(input bit wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(wr, a, d);
    #1;
    check(rst_pulse === exp_vec(), "R6 pulse vector", rst_pulse, exp_vec());
    check(bus_rdata === exp_read(a), "R7 read data", NB'(bus_rdata), NB'(exp_read(a)));
    if (watch_idx >= 0 && rst_pulse[watch_idx]) watch_hits++;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) cycle(1'b0, a, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) m_cnt[i] = 0;
    m_open = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h84; bus_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    idle(1, 8'h84);
    check(rst_pulse == '0, "R1 pulses after reset", rst_pulse, '0);
    check(bus_rdata == 32'h0, "R1 guard reads closed", NB'(bus_rdata), '0);

    // R5 locked write discarded
    cycle(1'b1, 8'h70, 32'hFFFF_FFFF);
    idle(2, 8'h70);
    check(rst_pulse == '0, "R5 locked write no pulse", rst_pulse, '0);

    // R4 stray value while closed
    cycle(1'b1, 8'h84, 32'h1234_5678);
    idle(1, 8'h84);
    check(bus_rdata == 32'h0, "R4 closed stays closed", NB'(bus_rdata), '0);

    // R2 open
    cycle(1'b1, 8'h84, KOPEN);
    check(bus_rdata == 32'h1, "R2 guard reads open", NB'(bus_rdata), NB'(1));

    // R4 stray value while open
    cycle(1'b1, 8'h84, KCLOSE ^ 32'h0000_0100);
    check(bus_rdata == 32'h1, "R4 open stays open", NB'(bus_rdata), NB'(1));

    // R6 exact pulse length, R7 read-back during and after
    watch_idx = 35; watch_hits = 0;
    cycle(1'b1, 8'h74, 32'h0000_0008);
    check(bus_rdata == 32'h8, "R7 read during pulse", NB'(bus_rdata), NB'(8));
    idle(8, 8'h74);
    check(watch_hits == PLEN, "R6 pulse length", NB'(watch_hits), NB'(PLEN));
    check(bus_rdata == 32'h0, "R7 self-cleared read", NB'(bus_rdata), '0);

    // R9 restart while active
    watch_idx = 70; watch_hits = 0;
    cycle(1'b1, 8'h78, 32'h0000_0040);
    idle(1, 8'h78);
    cycle(1'b1, 8'h78, 32'h0000_0040);
    idle(8, 8'h78);
    check(watch_hits == PLEN + 2, "R9 restarted length", NB'(watch_hits), NB'(PLEN + 2));
    watch_idx = -1;

    // R8 several words in one window
    cycle(1'b1, 8'h70, 32'h0000_0001);
    cycle(1'b1, 8'h80, 32'h8000_0000);
    check(rst_pulse[0] && rst_pulse[159], "R8 two words pulsing", rst_pulse,
          (NB'(1) | (NB'(1) << 159)));
    idle(6, 8'h70);

    // R10 stray addresses
    cycle(1'b1, 8'h00, 32'hFFFF_FFFF);
    cycle(1'b1, 8'h88, 32'hFFFF_FFFF);
    check(rst_pulse == '0 && bus_rdata == 32'h0, "R10 stray address", rst_pulse, '0);

    // R3 close then discard
    cycle(1'b1, 8'h84, KCLOSE);
    check(bus_rdata == 32'h0, "R3 guard reads closed", NB'(bus_rdata), '0);
    cycle(1'b1, 8'h7C, 32'hFFFF_FFFF);
    idle(1, 8'h7C);
    check(rst_pulse == '0, "R3 write after close dropped", rst_pulse, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] a;
      logic [31:0] d;
      bit wr = ($urandom_range(0, 3) != 0);
      if (sel < 2) begin
        a = 8'h84;
        case ($urandom_range(0, 2))
          0: d = KOPEN;
          1: d = KCLOSE;
          default: d = $urandom;
        endcase
      end else if (sel < 8) begin
        a = 8'(8'h70 + 4 * $urandom_range(0, 4));
        d = $urandom & $urandom & $urandom;
      end else begin
        a = 8'($urandom);
        d = $urandom;
      end
      cycle(wr, a, d);
    end

    finish_run();
  end
endmodule